// File: doc/BRIEF.md
# Switch-Fault Classifier with Cluster-Addressed Weight Layers

This block decides which of six power switches in a three-phase, three-level inverter has failed. Each request carries nine feature values: for each of the three phases, the spectral magnitude just below the carrier-order line, the magnitude just above it, and the difference between them. Every feature is quantized to an 8-bit level. The nine levels are joined into a 72-bit word. That word is cut into twenty-four 3-bit fields, and each field picks one of eight weight cells in its own row. Each of the six fault classes owns a separate weight layer, and a class score is the sum of the 24 cells that the word selects in that layer.

A request can be an inference or a training step. An inference walks the six layers in turn and returns the index of the best-scoring class together with its score. A training step scores the sample in the layer named by the supplied label. It returns that score, then moves every one of the 24 selected cells toward a target of 1.0 by a supervised update. Only the labelled layer changes. The host repeats training passes over its sample set until the returned scores reach the target or it has run its fixed number of epochs. After reset the block spends one cycle per cell clearing the whole weight store and reports busy while it does so.

Top module: `cmac_fault_classifier`

## Requirements
- R1: A feature x maps to level 0 when x < q_lo_i. Otherwise it maps to min(255, (x - q_lo_i) >> q_shift_i). Any value at or beyond the top of the range therefore gives level 255.
- R2: Feature j (j = 0..8) is taken from feat_i[(8-j)*16 +: 16], and its level occupies bits [(8-j)*8 +: 8] of the 72-bit word. Field k (k = 0..23) is bits [3k+2:3k] of the word, and its unsigned value selects the cell of row k.
- R3: A class score is the signed sum of the 24 selected cells of that class. Weights are two's complement with 16 fractional bits (1.0 = 65536).
- R4: A training step adds floor((65536 - s) * 43691 / 2^20) to each of the 24 selected cells of the labelled class, where s is that class's score before the step. The result saturates to the 24-bit weight range. No other class changes.
- R5: A training step finishes with done_o high, cls_o equal to the label and score_o equal to the score before the update.
- R6: An inference finishes with cls_o equal to the index (0..5) of the largest class score and score_o equal to that score. On a tie the lower index wins.
- R7: After reset, busy_o stays high for exactly 1152 cycles while every weight is cleared to zero. A reset applied later clears all training.
- R8: A request is taken on a clock edge where busy_o is low and start_i is high. done_o pulses for one cycle, 2 cycles after that edge for training and 7 cycles after it for inference. busy_o is high in between and low while done_o is high.
- R9: start_i is ignored while busy_o is high.
- R10: A training request whose label is 6 or 7 is not taken: busy_o stays low, no done_o follows, and no weight changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; starts the weight-clearing sweep |
| start_i | input | 1 | Request strobe, taken when busy_o is low |
| mode_i | input | 1 | 1 = training step, 0 = inference |
| label_i | input | 3 | Class to train (0..5), used in training only |
| feat_i | input | 144 | Nine 16-bit unsigned features, feature 0 in the top bits |
| q_lo_i | input | 16 | Lower end of the quantizing range |
| q_shift_i | input | 4 | Right shift giving the quantizing step of 2^q_shift_i |
| busy_o | output | 1 | High during the clearing sweep and while a request is in progress |
| done_o | output | 1 | One-cycle pulse when cls_o and score_o are valid |
| cls_o | output | 3 | Winning class (inference) or trained class (training) |
| score_o | output | 29 | Signed score with 16 fractional bits |

## Verification
The bench runs features below the range floor and far above its top. A quantizer that wraps instead of clamping would select other cells, and the scores would drift away from the trained value. Patterns that differ only in the lowest level bit of the ninth feature, or only in the top bit of the first, must each move exactly one field. A reversed byte order or field order would move several fields, or the wrong one. Two layers trained identically must tie, and the lower index must win; a comparison that uses greater-or-equal returns the higher index. Other sequences train a layer past the target so that the error turns negative, strobe start_i during busy, give an illegal label, and reset mid-run. A design that rounds the negative delta wrongly, accepts the extra strobe or the illegal label, or keeps weights through reset would show a wrong score on a later inference.

// File: rtl/cmac_cls_pkg.sv
`timescale 1ns/1ps
package cmac_cls_pkg;
    parameter int NFEAT    = 9;
    parameter int FEAT_W   = 16;
    parameter int SH_W     = 4;
    parameter int CODE_W   = 8;
    parameter int CLU_W    = 3;
    parameter int NCLS     = 6;
    parameter int WW       = 24;
    parameter int FRAC     = 16;
    parameter int RECIP_SH = 20;

    localparam int WORD_W      = NFEAT * CODE_W;
    localparam int NCLU        = WORD_W / CLU_W;
    localparam int NCELL       = 1 << CLU_W;
    localparam int CLS_IW      = $clog2(NCLS);
    localparam int CLU_IW      = $clog2(NCLU);
    localparam int ACC_W       = WW + CLU_IW;
    localparam int ERR_W       = ACC_W + 1;
    localparam int RECIP       = ((1 << RECIP_SH) + NCLU / 2) / NCLU;
    localparam int RCP_W       = $clog2(RECIP) + 1;
    localparam int DELTA_W     = ERR_W + RCP_W - RECIP_SH;
    localparam int TARGET      = 1 << FRAC;
    localparam int TOTAL_CELLS = NCLS * NCLU * NCELL;

    typedef enum logic [1:0] {ST_CLR, ST_IDLE, ST_SUM} cmac_st_e;

    typedef struct packed {
        cmac_st_e                 st;
        logic [CLS_IW-1:0]        clr_cls;
        logic [CLU_IW-1:0]        clr_clu;
        logic [CLU_W-1:0]         clr_cell;
        logic [WORD_W-1:0]        word;
        logic                     train;
        logic [CLS_IW-1:0]        cls_idx;
        logic [CLS_IW-1:0]        best_cls;
        logic signed [ACC_W-1:0]  best_sc;
        logic                     done;
        logic [CLS_IW-1:0]        res_cls;
        logic signed [ACC_W-1:0]  res_sc;
    } cmac_state_t;

    // Weight plus correction, clamped to the signed weight range.
    function automatic logic [WW-1:0] sat_add(input logic [WW-1:0] w,
                                              input logic [DELTA_W-1:0] d);
        logic signed [DELTA_W:0] s;
        logic signed [DELTA_W:0] hi;
        logic signed [DELTA_W:0] lo;
        hi = (DELTA_W+1)'((1 << (WW-1)) - 1);
        lo = ~hi;
        s  = (DELTA_W+1)'($signed(w)) + (DELTA_W+1)'($signed(d));
        if (s > hi)      sat_add = hi[WW-1:0];
        else if (s < lo) sat_add = lo[WW-1:0];
        else             sat_add = s[WW-1:0];
    endfunction
endpackage

// File: rtl/cmac_quantizer.sv
`timescale 1ns/1ps
module cmac_quantizer
    import cmac_cls_pkg::*;
#(
    parameter int XW = FEAT_W,
    parameter int SW = SH_W,
    parameter int CW = CODE_W
) (
    input  logic [XW-1:0] x_i,
    input  logic [XW-1:0] lo_i,
    input  logic [SW-1:0] sh_i,
    output logic [CW-1:0] code_o
);
    logic [XW-1:0] span;
    logic [XW-1:0] scaled;

    always_comb begin
        span   = (x_i >= lo_i) ? (x_i - lo_i) : '0;
        scaled = span >> sh_i;
        code_o = (scaled > XW'((1 << CW) - 1)) ? '1 : scaled[CW-1:0];
    end
endmodule

// File: rtl/cmac_score_sum.sv
`timescale 1ns/1ps
module cmac_score_sum
    import cmac_cls_pkg::*;
#(
    parameter int N  = NCLU,
    parameter int W  = WW,
    parameter int AW = ACC_W
) (
    input  logic [N*W-1:0]       w_i,
    output logic signed [AW-1:0] sum_o
);
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < N; k++) begin
            sum_o = sum_o + AW'($signed(w_i[k*W +: W]));
        end
    end
endmodule

// File: rtl/cmac_weight_bank.sv
`timescale 1ns/1ps
module cmac_weight_bank
    import cmac_cls_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 clr_en_i,
    input  logic [CLS_IW-1:0]    clr_cls_i,
    input  logic [CLU_IW-1:0]    clr_clu_i,
    input  logic [CLU_W-1:0]     clr_cell_i,
    input  logic [CLS_IW-1:0]    sel_cls_i,
    input  logic [WORD_W-1:0]    addr_i,
    input  logic                 upd_en_i,
    input  logic [DELTA_W-1:0]   upd_delta_i,
    output logic [NCLU*WW-1:0]   rd_o
);
    logic [WW-1:0] mem_q [NCLS][NCLU][NCELL];

    always_comb begin
        for (int k = 0; k < NCLU; k++) begin
            rd_o[k*WW +: WW] = mem_q[sel_cls_i][k][addr_i[k*CLU_W +: CLU_W]];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int c = 0; c < NCLS; c++) begin
            for (int k = 0; k < NCLU; k++) begin
                for (int e = 0; e < NCELL; e++) begin
                    if (clr_en_i && clr_cls_i == CLS_IW'(c) && clr_clu_i == CLU_IW'(k)
                        && clr_cell_i == CLU_W'(e)) begin
                        mem_q[c][k][e] <= '0;
                    end else if (upd_en_i && sel_cls_i == CLS_IW'(c)
                                 && addr_i[k*CLU_W +: CLU_W] == CLU_W'(e)) begin
                        mem_q[c][k][e] <= sat_add(mem_q[c][k][e], upd_delta_i);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cmac_fault_classifier.sv
`timescale 1ns/1ps
module cmac_fault_classifier
    import cmac_cls_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic                     mode_i,
    input  logic [CLS_IW-1:0]        label_i,
    input  logic [NFEAT*FEAT_W-1:0]  feat_i,
    input  logic [FEAT_W-1:0]        q_lo_i,
    input  logic [SH_W-1:0]          q_shift_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [CLS_IW-1:0]        cls_o,
    output logic signed [ACC_W-1:0]  score_o
);
    localparam logic signed [RCP_W-1:0] RCP_S = RCP_W'(RECIP);
    localparam int PROD_W = ERR_W + RCP_W;

    cmac_state_t st_d, st_q;

    logic [WORD_W-1:0]           word_now;
    logic [NCLU*WW-1:0]          rd_w;
    logic signed [ACC_W-1:0]     cls_sum;
    logic signed [ERR_W-1:0]     err;
    logic signed [PROD_W-1:0]    prod;
    logic [DELTA_W-1:0]          delta;
    logic                        clr_en;
    logic                        upd_en;
    logic                        accept;
    logic                        clr_last;

    // One quantizer per feature; feature 0 lands in the top byte.
    for (genvar j = 0; j < NFEAT; j++) begin : g_quant
        cmac_quantizer u_q (
            .x_i    (feat_i[(NFEAT-1-j)*FEAT_W +: FEAT_W]),
            .lo_i   (q_lo_i),
            .sh_i   (q_shift_i),
            .code_o (word_now[(NFEAT-1-j)*CODE_W +: CODE_W])
        );
    end

    cmac_weight_bank u_bank (
        .clk_i       (clk_i),
        .clr_en_i    (clr_en),
        .clr_cls_i   (st_q.clr_cls),
        .clr_clu_i   (st_q.clr_clu),
        .clr_cell_i  (st_q.clr_cell),
        .sel_cls_i   (st_q.cls_idx),
        .addr_i      (st_q.word),
        .upd_en_i    (upd_en),
        .upd_delta_i (delta),
        .rd_o        (rd_w)
    );

    cmac_score_sum u_sum (
        .w_i   (rd_w),
        .sum_o (cls_sum)
    );

    // Correction per cell: (target - score) / 24 by reciprocal multiply.
    always_comb begin
        err   = ERR_W'(TARGET) - ERR_W'(cls_sum);
        prod  = PROD_W'(err) * PROD_W'(RCP_S);
        delta = DELTA_W'(prod >>> RECIP_SH);
    end

    always_comb begin
        accept   = (st_q.st == ST_IDLE) && start_i
                   && (!mode_i || (label_i < CLS_IW'(NCLS)));
        clr_last = (st_q.clr_cls == CLS_IW'(NCLS-1)) && (st_q.clr_clu == CLU_IW'(NCLU-1))
                   && (st_q.clr_cell == CLU_W'(NCELL-1));
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_en    = 1'b0;
        upd_en    = 1'b0;
        unique case (st_q.st)
            ST_CLR: begin
                clr_en = 1'b1;
                if (clr_last) begin
                    st_d.st = ST_IDLE;
                end else if (st_q.clr_cell == CLU_W'(NCELL-1)) begin
                    st_d.clr_cell = '0;
                    if (st_q.clr_clu == CLU_IW'(NCLU-1)) begin
                        st_d.clr_clu = '0;
                        st_d.clr_cls = st_q.clr_cls + 1'b1;
                    end else begin
                        st_d.clr_clu = st_q.clr_clu + 1'b1;
                    end
                end else begin
                    st_d.clr_cell = st_q.clr_cell + 1'b1;
                end
            end
            ST_IDLE: begin
                if (accept) begin
                    st_d.st      = ST_SUM;
                    st_d.word    = word_now;
                    st_d.train   = mode_i;
                    st_d.cls_idx = mode_i ? label_i : '0;
                end
            end
            ST_SUM: begin
                if (st_q.train) begin
                    upd_en       = 1'b1;
                    st_d.res_cls = st_q.cls_idx;
                    st_d.res_sc  = cls_sum;
                    st_d.done    = 1'b1;
                    st_d.st      = ST_IDLE;
                end else begin
                    if (st_q.cls_idx == '0 || cls_sum > st_q.best_sc) begin
                        st_d.best_sc  = cls_sum;
                        st_d.best_cls = st_q.cls_idx;
                    end
                    if (st_q.cls_idx == CLS_IW'(NCLS-1)) begin
                        st_d.res_cls = st_d.best_cls;
                        st_d.res_sc  = st_d.best_sc;
                        st_d.done    = 1'b1;
                        st_d.st      = ST_IDLE;
                    end else begin
                        st_d.cls_idx = st_q.cls_idx + 1'b1;
                    end
                end
            end
            default: st_d.st = ST_CLR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= '0;
            st_q.st <= ST_CLR;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.st != ST_IDLE);
    assign done_o  = st_q.done;
    assign cls_o   = st_q.res_cls;
    assign score_o = st_q.res_sc;
endmodule

// File: rtl/cmac_fault_classifier_chk.sv
`timescale 1ns/1ps
module cmac_fault_classifier_chk
    import cmac_cls_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              mode_i,
    input logic [CLS_IW-1:0] label_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [CLS_IW-1:0] cls_o
);
    localparam int SW_W = $clog2(TOTAL_CELLS + 1);
    logic [SW_W-1:0] swp_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         swp_q <= '0;
        else if (swp_q < SW_W'(TOTAL_CELLS)) swp_q <= swp_q + 1'b1;
    end

    p_sweep_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swp_q < SW_W'(TOTAL_CELLS)) |-> busy_o);

    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    p_train_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && mode_i && label_i < CLS_IW'(NCLS)) |=> busy_o ##1 done_o);

    p_train_label_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && mode_i && label_i < CLS_IW'(NCLS))
        |=> ##1 (cls_o == $past(label_i, 2)));

    p_cls_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cls_o < CLS_IW'(NCLS)));

    p_bad_label_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && mode_i && label_i >= CLS_IW'(NCLS)) |=> !busy_o);
endmodule

bind cmac_fault_classifier cmac_fault_classifier_chk u_chk (.*);

// File: tb/sim_cmac_fault_classifier.sv
`timescale 1ns/1ps
module sim_cmac_fault_classifier;
    import cmac_cls_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [2:0] label = '0;
    logic [143:0] feat;
    logic [15:0] q_lo;
    logic [3:0] q_sh;
    logic busy, done;
    logic [2:0] cls;
    logic signed [28:0] score;

    int feats [9];
    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int ref_w [6][24][8];
    int m_clr = 0;
    int m_pend = 0;
    bit m_done = 0;
    bit m_train = 0;
    int m_label = 0;
    logic [71:0] m_word;
    int m_res_cls = 0;
    longint m_res_sc = 0;
    int got_cls = 0;
    longint got_sc = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int j = 0; j < 9; j++) feat[(8-j)*16 +: 16] = feats[j][15:0];
    end

    cmac_fault_classifier u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .label_i(label), .feat_i(feat), .q_lo_i(q_lo), .q_shift_i(q_sh),
        .busy_o(busy), .done_o(done), .cls_o(cls), .score_o(score)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int quant(int x);
        int v;
        if (x < int'(q_lo)) return 0;
        v = (x - int'(q_lo)) >> q_sh;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic logic [71:0] make_word();
        logic [71:0] w;
        for (int j = 0; j < 9; j++) w[(8-j)*8 +: 8] = 8'(quant(feats[j]));
        return w;
    endfunction

    function automatic longint class_sum(int c, logic [71:0] w);
        longint s = 0;
        for (int k = 0; k < 24; k++) s += ref_w[c][k][int'(w[3*k +: 3])];
        return s;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_clr = 1152; m_pend = 0; m_done = 0;
            foreach (ref_w[c, k, e]) ref_w[c][k][e] = 0;
        end else begin
            m_done = 0;
            if (m_clr > 0) begin
                m_clr--;
            end else if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    m_done = 1;
                    if (m_train) begin
                        longint s, d, nw;
                        s = class_sum(m_label, m_word);
                        d = ((longint'(65536) - s) * 43691) >>> 20;
                        m_res_cls = m_label; m_res_sc = s;
                        for (int k = 0; k < 24; k++) begin
                            nw = ref_w[m_label][k][int'(m_word[3*k +: 3])] + d;
                            if (nw > 8388607) nw = 8388607;
                            if (nw < -8388608) nw = -8388608;
                            ref_w[m_label][k][int'(m_word[3*k +: 3])] = int'(nw);
                        end
                    end else begin
                        m_res_cls = 0; m_res_sc = class_sum(0, m_word);
                        for (int c = 1; c < 6; c++) begin
                            if (class_sum(c, m_word) > m_res_sc) begin
                                m_res_cls = c; m_res_sc = class_sum(c, m_word);
                            end
                        end
                    end
                end
            end else if (start && (!mode || label < 3'd6)) begin
                m_word = make_word(); m_train = mode; m_label = int'(label);
                m_pend = mode ? 1 : 6;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        chk((m_clr > 0) ? "R7" : "R8", "busy", longint'(busy), longint'((m_clr > 0) || (m_pend > 0)));
        chk("R8", "done", longint'(done), longint'(m_done));
        if (m_done) begin
            chk(m_train ? "R5" : "R6", "class", longint'(cls), longint'(m_res_cls));
            chk(m_train ? "R5" : "R6", "score", longint'(score), m_res_sc);
            got_cls = int'(cls); got_sc = longint'(score);
        end
    endtask

    task automatic set_all(int v);
        for (int j = 0; j < 9; j++) feats[j] = v;
    endtask

    task automatic run_op(bit tr, int lb);
        start = 1'b1; mode = tr; label = 3'(lb);
        tick();
        start = 1'b0;
        for (int i = 0; i < 20 && !m_done; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        for (int i = 0; i < 1200; i++) tick();
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        q_lo = 16'd100; q_sh = 4'd2;
        set_all(100);
        // R7: sweep length and busy checked every cycle by the model
        do_reset();
        chk("R7", "idle after sweep", longint'(busy), 0);

        // R6 and R7: all weights zero, tie resolves to class 0
        run_op(0, 0);
        chk("R6", "zero tie class", got_cls, 0);
        chk("R7", "zero score", got_sc, 0);

        // R5: training returns the label and the pre-update score
        run_op(1, 2);
        chk("R5", "train label", got_cls, 2);
        chk("R5", "train pre-score", got_sc, 0);

        // R3 and R4: 24 cells of 2730 each
        run_op(0, 0);
        chk("R3", "trained score", got_sc, 65520);
        chk("R4", "trained class", got_cls, 2);

        // R1: below-floor feature clamps to level 0
        feats[3] = 20;
        run_op(0, 0);
        chk("R1", "below floor", got_sc, 65520);
        set_all(100);

        // R1: saturation at level 255; class 0 trained on a saturated pattern
        feats[0] = 60000;
        run_op(1, 0);
        feats[0] = 65000;
        run_op(0, 0);
        chk("R1", "saturated class", got_cls, 0);
        chk("R1", "saturated score", got_sc, 65520);
        set_all(100);

        // R2: ninth feature level 1 moves field 0 only
        feats[8] = 104;
        run_op(0, 0);
        chk("R2", "low field", got_sc, 62790);
        set_all(100);

        // R2: first feature level 128 moves field 23 only
        feats[0] = 612;
        run_op(0, 0);
        chk("R2", "high field class", got_cls, 2);
        chk("R2", "high field score", got_sc, 62790);
        set_all(100);

        // R9: a strobe while busy must not train class 1
        start = 1'b1; mode = 1'b0; label = 3'd0;
        tick();
        mode = 1'b1; label = 3'd1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 20 && !m_done; i++) tick();
        run_op(0, 0);
        chk("R9", "ignored strobe", got_cls, 2);

        // R10: label 7 is refused
        start = 1'b1; mode = 1'b1; label = 3'd7;
        tick();
        start = 1'b0;
        chk("R10", "busy after bad label", longint'(busy), 0);
        tick();
        chk("R10", "no done", longint'(done), 0);
        run_op(0, 0);
        chk("R10", "weights unchanged", got_sc, 65520);

        // R6: identical training of classes 3 and 5 ties, lower wins
        set_all(120);
        run_op(1, 3);
        run_op(1, 5);
        run_op(0, 0);
        chk("R6", "tie lower index", got_cls, 3);

        // R4: overshoot gives a negative correction
        set_all(100); feats[8] = 104;
        run_op(1, 2);
        set_all(100);
        run_op(1, 2);
        chk("R4", "overshoot above target", longint'(got_sc > 65536), 1);
        run_op(0, 0);

        // R4: repeated training converges on class 4
        set_all(100); feats[4] = 3000; feats[6] = 900;
        for (int i = 0; i < 5; i++) run_op(1, 4);
        run_op(0, 0);
        chk("R4", "converged class", got_cls, 4);

        // R7: reset mid-run clears every layer
        set_all(100);
        do_reset();
        run_op(0, 0);
        chk("R7", "cleared class", got_cls, 0);
        chk("R7", "cleared score", got_sc, 0);

        finish_run();
    end
endmodule